// File: doc/BRIEF.md
# Control Line Pulse Discriminator

This block sits at the edge of a module that a host steers through a single active-low control line. It brings the line into the module clock domain and measures how long each low excursion lasts. It then turns a width in one of two windows into a request for the internal controller. A long hold, in the tens of milliseconds, asks for a module reset. A brief hold of a few microseconds asks the module for attention, meaning the host wants it to act.

The same block drives an active-low busy line back to the host. That line is pulled low while the internal controller reports a running task. It is also pulled low from an accepted reset request until the controller reports that its reset sequence has finished.

All width limits are parameters counted in module clock cycles. The defaults suit a 25 MHz clock: 38 to 75 cycles for attention, and 2,000,000 to 3,000,000 cycles for reset.

Top module: `ctl_pulse_discrim`

## Requirements
- R1: After reset, attn_req_o and rst_req_o are 0. While task_active_i is 0, busy_n_o is 1.
- R2: A low pulse lasting from SHORT_MIN to SHORT_MAX clock samples, both bounds inclusive, produces exactly one cycle of attn_req_o. The output goes high after the sixth rising clock edge that follows the first edge sampling the line high again.
- R3: A low pulse lasting from LONG_MIN to LONG_MAX samples, both bounds inclusive, produces exactly one cycle of rst_req_o, with the same latency as R2.
- R4: A pulse whose width falls outside both windows raises neither request. This covers widths below SHORT_MIN, between SHORT_MAX and LONG_MIN, and just above LONG_MAX.
- R5: A low excursion shorter than GLITCH_CYC (4) consecutive samples starts no measurement and raises no request. A high blip shorter than GLITCH_CYC samples inside a low pulse does not end that pulse, so its cycles count toward the width.
- R6: The width counter saturates. A pulse of any length beyond LONG_MAX, however long, raises no request.
- R7: busy_n_o is 0 in every cycle in which task_active_i is 1.
- R8: busy_n_o is 0 from the cycle in which rst_req_o is 1 until rst_done_i is sampled 1 at a later clock edge. If rst_done_i is sampled 1 at the same edge on which the hold would begin, the hold wins, and rst_done_i must be sampled again to release it.
- R9: attn_req_o and rst_req_o are never 1 in the same cycle, and each stays 1 for one cycle only.
- R10: The width is the number of clock samples for which the filtered line is low. It is evaluated only once the line returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| ctl_n_i | input | 1 | Raw asynchronous active-low control line from the host |
| task_active_i | input | 1 | Internal controller reports a task in progress |
| rst_done_i | input | 1 | Internal controller reports that its reset sequence is complete |
| attn_req_o | output | 1 | One-cycle attention request |
| rst_req_o | output | 1 | One-cycle reset request |
| busy_n_o | output | 1 | Busy line to the host, low while busy |

## Verification
Two updates to the busy hold can fall on the same clock edge: the set caused by a newly accepted long pulse, and the clear requested by rst_done_i. The bench provokes this by raising rst_done_i before a valid long pulse ends and keeping it high past the request. It expects busy_n_o to stay low for exactly the request cycle and one further cycle, then to rise. A behavioural model tracks the filtered line, the widths and the busy state, and it is compared against the outputs on every clock.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_SHORT = 2'd1,
        CLS_LONG  = 2'd2
    } width_cls_e;

endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], raw_i};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '{sh: '1};
        else       st_q <= st_d;
    end

    assign sync_o = st_q.sh[STAGES-1];

endmodule

// File: rtl/cpd_deglitch.sv
module cpd_deglitch #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sync_i,
    output logic level_o
);

    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] run;
    } dg_st_t;

    dg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i != st_q.level) begin
            if (st_q.run == CW'(GLITCH_CYC - 1)) begin
                st_d.level = sync_i;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '{level: 1'b1, run: '0};
        else       st_q <= st_d;
    end

    assign level_o = st_q.level;

    AST_LEVEL_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.level != $past(st_q.level)) |-> ($past(sync_i) == st_q.level)) // R5
        else $error("filtered level moved against its input");

    AST_RUN_BOUNDED: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.run < CW'(GLITCH_CYC)) // R5
        else $error("deglitch run counter out of range");

endmodule

// File: rtl/cpd_width_class.sv
module cpd_width_class
    import cpd_pkg::*;
#(
    parameter int SHORT_MIN = 38,
    parameter int SHORT_MAX = 75,
    parameter int LONG_MIN  = 2000000,
    parameter int LONG_MAX  = 3000000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic attn_o,
    output logic rreq_o
);

    localparam int SAT = LONG_MAX + 1;
    localparam int CW  = $clog2(SAT + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] width;
        logic          attn;
        logic          rreq;
    } wc_st_t;

    wc_st_t     st_d, st_q;
    width_cls_e cls;

    function automatic width_cls_e classify(input logic [CW-1:0] w);
        if (w >= CW'(SHORT_MIN) && w <= CW'(SHORT_MAX)) return CLS_SHORT;
        if (w >= CW'(LONG_MIN)  && w <= CW'(LONG_MAX))  return CLS_LONG;
        return CLS_NONE;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        st_d.attn = 1'b0;
        st_d.rreq = 1'b0;
        cls       = CLS_NONE;
        if (!level_i) begin
            if (st_q.prev)                   st_d.width = CW'(1);
            else if (st_q.width != CW'(SAT)) st_d.width = st_q.width + 1'b1;
        end else if (!st_q.prev) begin
            cls        = classify(st_q.width);
            st_d.attn  = (cls == CLS_SHORT);
            st_d.rreq  = (cls == CLS_LONG);
            st_d.width = '0;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '{prev: 1'b1, width: '0, attn: 1'b0, rreq: 1'b0};
        else       st_q <= st_d;
    end

    assign attn_o = st_q.attn;
    assign rreq_o = st_q.rreq;

    AST_WIDTH_SATURATES: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.width <= CW'(SAT)) // R6
        else $error("width counter passed its ceiling");

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(st_q.attn && st_q.rreq)) // R9
        else $error("both requests raised together");

    AST_ATTN_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.attn |=> !st_q.attn) // R9
        else $error("attention request longer than one cycle");

    AST_RREQ_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.rreq |=> !st_q.rreq) // R9
        else $error("reset request longer than one cycle");

    AST_REQ_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.attn || st_q.rreq) |-> (st_q.prev && !$past(st_q.prev))) // R10
        else $error("request raised away from a rising edge");

endmodule

// File: rtl/ctl_pulse_discrim.sv
module ctl_pulse_discrim #(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_CYC  = 4,
    parameter int SHORT_MIN   = 38,
    parameter int SHORT_MAX   = 75,
    parameter int LONG_MIN    = 2000000,
    parameter int LONG_MAX    = 3000000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ctl_n_i,
    input  logic task_active_i,
    input  logic rst_done_i,
    output logic attn_req_o,
    output logic rst_req_o,
    output logic busy_n_o
);

    typedef struct packed {
        logic hold;
    } top_st_t;

    logic    sync_w;
    logic    level_w;
    logic    attn_w;
    logic    rreq_w;
    top_st_t st_d, st_q;

    cpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (ctl_n_i),
        .sync_o (sync_w)
    );

    cpd_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_deglitch (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .sync_i  (sync_w),
        .level_o (level_w)
    );

    cpd_width_class #(
        .SHORT_MIN (SHORT_MIN),
        .SHORT_MAX (SHORT_MAX),
        .LONG_MIN  (LONG_MIN),
        .LONG_MAX  (LONG_MAX)
    ) u_class (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (level_w),
        .attn_o  (attn_w),
        .rreq_o  (rreq_w)
    );

    always_comb begin
        st_d = st_q;
        if (rreq_w)          st_d.hold = 1'b1;
        else if (rst_done_i) st_d.hold = 1'b0;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '{hold: 1'b0};
        else       st_q <= st_d;
    end

    assign attn_req_o = attn_w;
    assign rst_req_o  = rreq_w;
    assign busy_n_o   = ~(task_active_i | st_q.hold | rreq_w);

    AST_HOLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |=> !busy_n_o) // R8
        else $error("busy released right after a reset request");

    AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(busy_n_o) && !$past(task_active_i) && !$past(rst_done_i)
         && !$past(rst_req_o)) |-> !busy_n_o) // R8
        else $error("busy hold dropped without completion");

endmodule

// File: tb/ctl_pulse_discrim_tb.sv
module ctl_pulse_discrim_tb_top;

    localparam int SHORT_MIN = 38;
    localparam int SHORT_MAX = 75;
    localparam int LONG_MIN  = 300;
    localparam int LONG_MAX  = 500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_n = 1'b1;
    logic task_active = 1'b0;
    logic rst_done = 1'b0;
    logic attn_req, rst_req, busy_n;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    ctl_pulse_discrim #(
        .SYNC_STAGES (2),
        .GLITCH_CYC  (4),
        .SHORT_MIN   (SHORT_MIN),
        .SHORT_MAX   (SHORT_MAX),
        .LONG_MIN    (LONG_MIN),
        .LONG_MAX    (LONG_MAX)
    ) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .ctl_n_i       (ctl_n),
        .task_active_i (task_active),
        .rst_done_i    (rst_done),
        .attn_req_o    (attn_req),
        .rst_req_o     (rst_req),
        .busy_n_o      (busy_n)
    );

    // behavioural reference
    logic [3:0] hist;
    bit   filt_m;
    int   low_len;
    bit   pa [4];
    bit   pr [4];
    bit   hold_m;

    always @(posedge clk) begin
        bit new_f, ea, er;
        if (rst) begin
            hist = 4'hF; filt_m = 1; low_len = 0; hold_m = 0;
            for (int i = 0; i < 4; i++) begin pa[i] = 0; pr[i] = 0; end
        end else begin
            if (pr[3]) hold_m = 1;
            else if (rst_done) hold_m = 0;
            hist  = {hist[2:0], ctl_n};
            new_f = filt_m;
            if (hist == 4'hF) new_f = 1;
            if (hist == 4'h0) new_f = 0;
            ea = 0; er = 0;
            if (!new_f) begin
                low_len = filt_m ? 1 : low_len + 1;
            end else if (!filt_m) begin
                ea = (low_len >= SHORT_MIN && low_len <= SHORT_MAX);
                er = (low_len >= LONG_MIN && low_len <= LONG_MAX);
                low_len = 0;
            end
            filt_m = new_f;
            for (int i = 3; i > 0; i--) begin pa[i] = pa[i-1]; pr[i] = pr[i-1]; end
            pa[0] = ea; pr[0] = er;
        end
    end

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            bit exp_busy;
            exp_busy = !(task_active || hold_m || pr[3]);
            checks++;
            if (attn_req !== pa[3]) begin
                fails++;
                $display("FAIL %s attn_req actual=%b expected=%b t=%0t", cur_req, attn_req, pa[3], $time);
            end
            checks++;
            if (rst_req !== pr[3]) begin
                fails++;
                $display("FAIL %s rst_req actual=%b expected=%b t=%0t", cur_req, rst_req, pr[3], $time);
            end
            checks++;
            if (busy_n !== exp_busy) begin
                fails++;
                $display("FAIL %s busy_n actual=%b expected=%b t=%0t", cur_req, busy_n, exp_busy, $time);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic low_pulse(input int n);
        @(negedge clk);
        ctl_n = 1'b0;
        idle(n);
        ctl_n = 1'b1;
        idle(20);
    endtask

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(3);
        cur_req = "R1";
        expect_bit("R1 attn_req", attn_req, 1'b0);
        expect_bit("R1 rst_req", rst_req, 1'b0);
        expect_bit("R1 busy_n", busy_n, 1'b1);

        cur_req = "R2"; low_pulse(SHORT_MIN); low_pulse(SHORT_MAX); low_pulse(50);
        cur_req = "R4"; low_pulse(SHORT_MIN - 1); low_pulse(SHORT_MAX + 1);
        low_pulse(150); low_pulse(LONG_MIN - 1); low_pulse(LONG_MAX + 1);
        cur_req = "R5"; low_pulse(3); low_pulse(1); low_pulse(4);
        // a 2-sample high blip inside a 52-sample low stays part of the pulse
        @(negedge clk); ctl_n = 1'b0; idle(25); ctl_n = 1'b1; idle(2);
        ctl_n = 1'b0; idle(25); ctl_n = 1'b1; idle(20);
        cur_req = "R10"; low_pulse(SHORT_MAX - 1);
        cur_req = "R3"; low_pulse(LONG_MIN); idle(5);
        @(negedge clk); rst_done = 1'b1; @(negedge clk); rst_done = 1'b0;
        low_pulse(LONG_MAX);
        cur_req = "R8"; idle(10);
        expect_bit("R8 busy_n held", busy_n, 1'b0);
        @(negedge clk); rst_done = 1'b1; @(negedge clk); rst_done = 1'b0;
        idle(2);
        expect_bit("R8 busy_n released", busy_n, 1'b1);
        // completion raised across the acceptance edge: set must win
        @(negedge clk); ctl_n = 1'b0; idle(400);
        rst_done = 1'b1; ctl_n = 1'b1; idle(20); rst_done = 1'b0;
        expect_bit("R8 busy_n after collision", busy_n, 1'b1);
        cur_req = "R6"; low_pulse(2000);
        cur_req = "R7";
        @(negedge clk); task_active = 1'b1; idle(3);
        expect_bit("R7 busy_n with task", busy_n, 1'b0);
        low_pulse(60);
        task_active = 1'b0; idle(3);
        expect_bit("R7 busy_n idle", busy_n, 1'b1);
        cur_req = "R9"; low_pulse(SHORT_MIN + 5); low_pulse(LONG_MIN + 50);
        @(negedge clk); rst_done = 1'b1; @(negedge clk); rst_done = 1'b0;
        idle(10);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule